// File: doc/BRIEF.md
# Interleaved Multi-Lane Delay Line

This block is a fixed-length delay line. A word entering on `din` leaves on `dout` exactly as it would from a single chain of `DEPTH` registers clocked every cycle. Internally it does not use such a chain. The stages are split into `LANES` parallel lanes, and each lane holds `DEPTH/LANES` stages. A modulo-`LANES` phase counter enables one lane per cycle. Successive input words therefore land in the lanes in rotation, and each lane advances only once every `LANES` cycles.

An output multiplexer, steered by the same phase value, picks the lane whose oldest stage holds the word due on the current cycle. All registers run on the one base clock and use clock enables, so the design has no derived clocks. With `LANES` set to 1 the block is an ordinary shift register. Settings 2 and 4 trade a wider output multiplexer for a lower toggle rate in each stage.

Top module: `ilv_shift_reg`

## Requirements
- R1: After any clock edge, `dout` equals the `din` word captured `DEPTH-1` edges earlier, so each word is visible on `dout` `DEPTH` cycles after it is presented. This holds for `LANES` = 1, 2 and 4 with `DEPTH` = 16.
- R2: The phase counter starts at 0, steps by one on every clock edge, and wraps from `LANES-1` to 0.
- R3: Exactly one lane is enabled on each edge, and it is the lane whose index equals the phase. That lane shifts and takes the `din` word into its first stage.
- R4: A lane that is not enabled keeps all of its stages unchanged.
- R5: The output multiplexer presents the last stage of the lane whose index equals the current phase value, and that value always lies below `LANES`.
- R6: Synchronous reset clears every stage of every lane and sets the phase to 0. `dout` reads all zeros after a reset edge and stays zero until the first word captured after reset arrives.
- R7: Each lane holds `DEPTH/LANES` stages, and `DEPTH` must be a multiple of `LANES`. A single nonzero word therefore appears on `dout` for exactly one cycle, `DEPTH` cycles after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; every register in the block uses it |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Serial input word, one per cycle |
| dout | output | WIDTH | Serial output word, delayed by DEPTH cycles |

## Verification
Three instances with one, two and four lanes run side by side against a plain shift register kept in the bench.

The instances are driven with the following input patterns:
- **All zeros.** Shows the reset state and rules out spurious output.
- **Single isolated word.** Pins down the exact latency and shows that the word appears once and only once.
- **Alternating words.** Separates the even and odd lanes, so swapped lanes or a mis-phased multiplexer show up at once.
- **Ramp of distinct values.** Exposes any reordering among four lanes.
- **Long pseudo-random stream.** Exercises the lanes in general.
- **Mid-stream reset.** Checks that stored data is really cleared.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Stages held by each lane
  function automatic int unsigned lane_stages(int unsigned depth, int unsigned lanes);
    return depth / lanes;
  endfunction

  // Phase that follows ph in a modulo-lanes rotation
  function automatic int unsigned phase_after(int unsigned ph, int unsigned lanes);
    return (ph + 1 >= lanes) ? 0 : ph + 1;
  endfunction

  // Width of a phase register for a given lane count (at least one bit)
  function automatic int unsigned phase_bits(int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/ilv_phase_ctr.sv
module ilv_phase_ctr #(
  parameter int unsigned LANES = 2,
  localparam int unsigned PW = ilv_pkg::phase_bits(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PW-1:0]    phase,
  output logic [LANES-1:0] lane_en
);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= PW'(ilv_pkg::phase_after(32'(ph_q), LANES));
  end

  assign phase = ph_q;

  for (genvar j = 0; j < LANES; j++) begin : g_en
    assign lane_en[j] = (32'(ph_q) == j);
  end

  // R2: the last phase is followed by phase 0
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (32'(phase) == LANES - 1) |=> (phase == '0));

  // R2: the phase advances by one everywhere else
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    (32'(phase) < LANES - 1) |=> (32'(phase) == 32'($past(phase)) + 1));

  // R6: reset returns the phase to 0
  a_r6_phase_reset: assert property (@(posedge clk)
    rst |=> (phase == '0));

endmodule

// File: rtl/ilv_lane_chain.sv
module ilv_lane_chain #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tail
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign tail = stg[STAGES-1];

  // R3: an enabled lane takes the input word into its first stage
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    en |=> (stg[0] == $past(din)));

  // R4: a lane that is not enabled keeps its contents
  a_r4_hold_first: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(stg[0]));

  // R4: the oldest stage is likewise held while the lane is idle
  a_r4_hold_tail: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(tail));

  // R6: reset clears the lane
  a_r6_lane_reset: assert property (@(posedge clk)
    rst |=> (tail == '0 && stg[0] == '0));

endmodule

// File: rtl/ilv_out_mux.sv
module ilv_out_mux #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned LANES = 2,
  localparam int unsigned PW = ilv_pkg::phase_bits(LANES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANES-1:0][WIDTH-1:0] tails,
  input  logic [PW-1:0]               sel,
  output logic [WIDTH-1:0]            dout
);

  always_comb begin
    dout = '0;
    for (int j = 0; j < LANES; j++) begin
      if (32'(sel) == j) dout = tails[j];
    end
  end

  // R5: the select never names a lane that does not exist
  a_r5_sel_range: assert property (@(posedge clk) disable iff (rst)
    32'(sel) < LANES);

endmodule

// File: rtl/ilv_shift_reg.sv
module ilv_shift_reg #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned PW     = ilv_pkg::phase_bits(LANES);
  localparam int unsigned STAGES = ilv_pkg::lane_stages(DEPTH, LANES);

  // Named internal events, brought out for the assertions
  logic [PW-1:0]               phase;
  logic [LANES-1:0]            lane_en;
  logic [LANES-1:0][WIDTH-1:0] lane_tail;

  ilv_phase_ctr #(.LANES(LANES)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .lane_en (lane_en)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    ilv_lane_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain (
      .clk  (clk),
      .rst  (rst),
      .en   (lane_en[j]),
      .din  (din),
      .tail (lane_tail[j])
    );
  end

  ilv_out_mux #(.WIDTH(WIDTH), .LANES(LANES)) u_mux (
    .clk   (clk),
    .rst   (rst),
    .tails (lane_tail),
    .sel   (phase),
    .dout  (dout)
  );

  // R3: exactly one lane is enabled in every cycle
  a_r3_one_lane: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_en) == 1);

  // R6: after a reset edge the output reads zero
  a_r6_out_reset: assert property (@(posedge clk)
    rst |=> (dout == '0));

endmodule

// File: tb/tb_ilv_shift_reg.sv
`timescale 1ns/1ps
module tb_ilv_shift_reg;

  localparam int unsigned W = 4;
  localparam int unsigned L = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout_l1, dout_l2, dout_l4;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ilv_shift_reg #(.WIDTH(W), .DEPTH(L), .LANES(1)) dut_l1 (
    .clk(clk), .rst(rst), .din(din), .dout(dout_l1));
  ilv_shift_reg #(.WIDTH(W), .DEPTH(L), .LANES(2)) dut (
    .clk(clk), .rst(rst), .din(din), .dout(dout_l2));
  ilv_shift_reg #(.WIDTH(W), .DEPTH(L), .LANES(4)) dut_l4 (
    .clk(clk), .rst(rst), .din(din), .dout(dout_l4));

  // Reference: one plain full-rate chain
  logic [W-1:0] refq [L];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) refq[i] <= '0;
    end else begin
      refq[0] <= din;
      for (int i = 1; i < L; i++) refq[i] <= refq[i-1];
    end
  end

  task automatic chk(string tag, string name, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "lanes1", dout_l1, refq[L-1]);
    chk(tag, "lanes2", dout_l2, refq[L-1]);
    chk(tag, "lanes4", dout_l4, refq[L-1]);
  endtask

  // Sample the outputs left by the last edge, then present the next word
  task automatic step(string tag, logic [W-1:0] v);
    @(negedge clk);
    chk_all(tag);
    din = v;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // R6: outputs are zero while reset is held
    repeat (3) begin
      @(negedge clk);
      chk("R6 reset", "lanes1", dout_l1, '0);
      chk("R6 reset", "lanes2", dout_l2, '0);
      chk("R6 reset", "lanes4", dout_l4, '0);
    end
    rst = 1'b0;

    // R1: all-zero input
    for (int k = 0; k < 20; k++) step("R1 zeros", '0);

    // R7: one isolated word appears once, exactly DEPTH cycles later
    step("R7 impulse", 4'hF);
    for (int k = 0; k < L - 1; k++) begin
      step("R7 impulse", '0);
      chk("R7 before", "lanes4", dout_l4, '0);
    end
    @(negedge clk);
    chk("R7 arrival", "lanes1", dout_l1, 4'hF);
    chk("R7 arrival", "lanes2", dout_l2, 4'hF);
    chk("R7 arrival", "lanes4", dout_l4, 4'hF);
    @(negedge clk);
    chk("R7 once", "lanes2", dout_l2, '0);
    chk("R7 once", "lanes4", dout_l4, '0);

    // R3 R4 R5: alternating words separate the lanes
    for (int k = 0; k < 48; k++) step("R3 R4 R5 alternating", (k % 2 == 0) ? 4'h5 : 4'hA);

    // R2 R5: ramp of distinct values exposes lane ordering
    for (int k = 0; k < 64; k++) step("R2 R5 ramp", W'(k));

    // R1: pseudo-random stream
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R1 random", lfsr[W-1:0]);
    end

    // R6: reset in mid-stream clears the stored data
    @(negedge clk);
    rst = 1'b1;
    din = 4'h9;
    @(negedge clk);
    chk("R6 midreset", "lanes1", dout_l1, '0);
    chk("R6 midreset", "lanes2", dout_l2, '0);
    chk("R6 midreset", "lanes4", dout_l4, '0);
    rst = 1'b0;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R6 R1 after reset", lfsr[W-1:0] | 4'h1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule